// File: doc/BRIEF.md
# Shadowed PWM Register Bank

This block is the configuration register file that sits in front of a multi-channel PWM generator. A simple single-cycle bus writes and reads byte-wide settings held at word-aligned addresses. The settings are a shared clock prescaler, a shared period length, per-channel enable bits, and for each channel a rise-edge and a fall-edge position. The block drives the settings currently in force straight to the generator. It does not generate waveforms itself.

A build-time mask picks which channels get a second, staging copy of their two edge registers. While the global synchronous-update bit is set, bus writes to the edge registers of those channels go only to the staging copy. The staged pair becomes active at the next period-start strobe from the generator, so a period that has already begun ends with its old edges. Channels outside the mask, and all channels while the bit is clear, take edge writes at once. Readback always shows the values in force and never the staged ones.

Top module: `pwm_regbank`

## Requirements
- R1: Reset (active high, synchronous) sets every active register, every staging register and the synchronous-update bit to 0, so all outputs and all readback values are 0.
- R2: Address map (byte addresses, bits 7:0 of write data stored): 0x00 prescaler, 0x04 period, 0x08 enable bits for channels 0..7 (bit n = channel n), 0x0C enable bits for channels 8..15 (bit n = channel 8+n), 0x10+8*c rise edge of channel c, 0x14+8*c fall edge of channel c, 0xE4 synchronous-update bit in bit 0.
- R3: While read enable is high, read data bits 7:0 hold the active value of the addressed register and bits 31:8 are 0. While read enable is low, read data is 0.
- R4: Unmapped addresses read as 0 and writes to them change nothing. Unmapped means: any address not a multiple of 4, any address not listed in R2, edge addresses of channels at or above the channel count, and 0x0C when there are 8 channels or fewer. Enable bits for channels that do not exist read as 0.
- R5: An edge write to a channel outside the shadow mask appears on the outputs and on readback in the next cycle, whatever the synchronous-update bit is.
- R6: Prescaler, period and enable writes appear on the outputs and on readback in the next cycle, whatever the synchronous-update bit is.
- R7: With the synchronous-update bit clear, an edge write to a shadowed channel appears in the next cycle and also loads its staging copy, so a later commit does not bring back an older value.
- R8: With the synchronous-update bit set, an edge write to a shadowed channel leaves its active edge unchanged. At the next period-start strobe the active edge takes the latest staged value, which shows from the cycle after the strobe.
- R9: An edge write to a shadowed channel in the same cycle as a period-start strobe (bit set) is staged for the following strobe; that strobe's commit uses the staged value from before the write.
- R10: A period-start strobe while the synchronous-update bit is clear leaves every active register unchanged, and any pending staged value stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data, bits 7:0 used |
| bus_rdata | output | 32 | Read data, combinational from address |
| period_start | input | 1 | Period-start pulse from the generator |
| act_prescale | output | 8 | Prescaler in force |
| act_period | output | 8 | Period length in force |
| act_enable | output | NUM_CH | Channel enables in force |
| act_rise | output | 8*NUM_CH | Rise edges in force, channel c at bits 8c+7:8c |
| act_fall | output | 8*NUM_CH | Fall edges in force, channel c at bits 8c+7:8c |

## Verification
The bench builds the bank with ten channels and a shadow mask of 10'b10_0101_0011, so shadowed and plain channels sit next to each other. Both enable bytes are then mapped, but only two bits of the upper byte exist, and edge addresses for channels 10 to 15 fall into the unmapped range. That size keeps a full sweep of all 256 addresses short, and it puts every decode boundary in reach: alignment, missing channels, partial enable bytes and each staging case.

// File: rtl/pwm_regbank_pkg.sv
package pwm_regbank_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned MAX_CH  = 16;
    localparam int unsigned IDX_W   = $clog2(MAX_CH);

    localparam logic [ADDR_W-1:0] A_PRESCALE = 8'h00;
    localparam logic [ADDR_W-1:0] A_PERIOD   = 8'h04;
    localparam logic [ADDR_W-1:0] A_EN_LO    = 8'h08;
    localparam logic [ADDR_W-1:0] A_EN_HI    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_EDGE_LO  = 8'h10;
    localparam logic [ADDR_W-1:0] A_EDGE_HI  = 8'h8C;
    localparam logic [ADDR_W-1:0] A_SYNC     = 8'hE4;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRESCALE,
        RK_PERIOD,
        RK_ENABLE,
        RK_RISE,
        RK_FALL,
        RK_SYNC
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic [REG_W-1:0] rise;
        logic [REG_W-1:0] fall;
    } edge_pair_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned nch);
        reg_sel_t         s;
        logic [ADDR_W-1:0] off;
        s.kind = RK_NONE;
        s.idx  = '0;
        off    = a - A_EDGE_LO;
        if (a[1:0] == 2'b00) begin
            if (a == A_PRESCALE) begin
                s.kind = RK_PRESCALE;
            end else if (a == A_PERIOD) begin
                s.kind = RK_PERIOD;
            end else if (a == A_EN_LO) begin
                s.kind = RK_ENABLE;
            end else if (a == A_EN_HI && nch > 8) begin
                s.kind = RK_ENABLE;
                s.idx  = IDX_W'(1);
            end else if (a == A_SYNC) begin
                s.kind = RK_SYNC;
            end else if (a >= A_EDGE_LO && a <= A_EDGE_HI) begin
                if (int'(off[6:3]) < nch) begin
                    s.kind = off[2] ? RK_FALL : RK_RISE;
                    s.idx  = off[6:3];
                end
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/pwm_rb_decode.sv
module pwm_rb_decode
    import pwm_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        sel = decode_addr(addr, NUM_CH);
    end
endmodule

// File: rtl/pwm_rb_channel.sv
module pwm_rb_channel
    import pwm_regbank_pkg::*;
#(
    parameter bit SHADOWED = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_rise,
    input  logic             wr_fall,
    input  logic [REG_W-1:0] wdata,
    input  logic             sync_on,
    input  logic             period_start,
    output edge_pair_t       act
);
    edge_pair_t act_q;

    generate
        if (SHADOWED) begin : g_shadow
            edge_pair_t stage_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    act_q   <= '0;
                    stage_q <= '0;
                end else begin
                    if (period_start && sync_on) begin
                        act_q <= stage_q;
                    end
                    if (wr_rise) begin
                        stage_q.rise <= wdata;
                        if (!sync_on) act_q.rise <= wdata;
                    end
                    if (wr_fall) begin
                        stage_q.fall <= wdata;
                        if (!sync_on) act_q.fall <= wdata;
                    end
                end
            end
        end else begin : g_plain
            logic unused_ctl;
            assign unused_ctl = sync_on ^ period_start;
            always_ff @(posedge clk) begin
                if (rst) begin
                    act_q <= '0;
                end else begin
                    if (wr_rise) act_q.rise <= wdata;
                    if (wr_fall) act_q.fall <= wdata;
                end
            end
        end
    endgenerate

    assign act = act_q;
endmodule

// File: rtl/pwm_rb_readmux.sv
module pwm_rb_readmux
    import pwm_regbank_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic                          rd,
    input  reg_sel_t                      sel,
    input  logic [REG_W-1:0]              prescale,
    input  logic [REG_W-1:0]              period,
    input  logic [NUM_CH-1:0]             enable,
    input  logic [NUM_CH-1:0][REG_W-1:0]  rise,
    input  logic [NUM_CH-1:0][REG_W-1:0]  fall,
    input  logic                          sync_on,
    output logic [BUS_W-1:0]              rdata
);
    logic [REG_W-1:0] val;

    always_comb begin
        val = '0;
        unique case (sel.kind)
            RK_PRESCALE: val = prescale;
            RK_PERIOD:   val = period;
            RK_SYNC:     val = {{(REG_W-1){1'b0}}, sync_on};
            RK_ENABLE: begin
                for (int ch = 0; ch < int'(NUM_CH); ch++) begin
                    if (sel.idx == IDX_W'(ch / 8)) val[ch % 8] = enable[ch];
                end
            end
            RK_RISE: begin
                for (int ch = 0; ch < int'(NUM_CH); ch++) begin
                    if (sel.idx == IDX_W'(ch)) val = rise[ch];
                end
            end
            RK_FALL: begin
                for (int ch = 0; ch < int'(NUM_CH); ch++) begin
                    if (sel.idx == IDX_W'(ch)) val = fall[ch];
                end
            end
            default: val = '0;
        endcase
        rdata = rd ? {{(BUS_W-REG_W){1'b0}}, val} : '0;
    end
endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
    import pwm_regbank_pkg::*;
#(
    parameter int unsigned       NUM_CH      = 16,
    parameter logic [NUM_CH-1:0] SHADOW_MASK = {NUM_CH{1'b1}}
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic                    period_start,
    output logic [7:0]              act_prescale,
    output logic [7:0]              act_period,
    output logic [NUM_CH-1:0]       act_enable,
    output logic [NUM_CH*8-1:0]     act_rise,
    output logic [NUM_CH*8-1:0]     act_fall
);
    localparam int unsigned EN_BYTES = (NUM_CH + 7) / 8;

    reg_sel_t                      sel;
    logic [REG_W-1:0]              prescale_q;
    logic [REG_W-1:0]              period_q;
    logic [NUM_CH-1:0]             enable_q;
    logic                          sync_q;
    logic [NUM_CH-1:0][REG_W-1:0]  rise_w;
    logic [NUM_CH-1:0][REG_W-1:0]  fall_w;
    logic [REG_W-1:0]              wbyte;
    logic                          unused_wdata_hi;

    assign wbyte           = bus_wdata[REG_W-1:0];
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:REG_W];

    pwm_rb_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prescale_q <= '0;
            period_q   <= '0;
            enable_q   <= '0;
            sync_q     <= 1'b0;
        end else if (bus_wr) begin
            if (sel.kind == RK_PRESCALE) prescale_q <= wbyte;
            if (sel.kind == RK_PERIOD)   period_q   <= wbyte;
            if (sel.kind == RK_SYNC)     sync_q     <= wbyte[0];
            for (int ch = 0; ch < int'(NUM_CH); ch++) begin
                if (sel.kind == RK_ENABLE && int'(sel.idx) == ch / 8 && ch / 8 < int'(EN_BYTES))
                    enable_q[ch] <= wbyte[ch % 8];
            end
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            edge_pair_t pair;
            logic       wr_r;
            logic       wr_f;
            assign wr_r = bus_wr && sel.kind == RK_RISE && sel.idx == IDX_W'(c);
            assign wr_f = bus_wr && sel.kind == RK_FALL && sel.idx == IDX_W'(c);

            pwm_rb_channel #(.SHADOWED(SHADOW_MASK[c])) u_ch (
                .clk          (clk),
                .rst          (rst),
                .wr_rise      (wr_r),
                .wr_fall      (wr_f),
                .wdata        (wbyte),
                .sync_on      (sync_q),
                .period_start (period_start),
                .act          (pair)
            );
            assign rise_w[c] = pair.rise;
            assign fall_w[c] = pair.fall;
        end
    endgenerate

    pwm_rb_readmux #(.NUM_CH(NUM_CH)) u_rmux (
        .rd       (bus_rd),
        .sel      (sel),
        .prescale (prescale_q),
        .period   (period_q),
        .enable   (enable_q),
        .rise     (rise_w),
        .fall     (fall_w),
        .sync_on  (sync_q),
        .rdata    (bus_rdata)
    );

    assign act_prescale = prescale_q;
    assign act_period   = period_q;
    assign act_enable   = enable_q;
    assign act_rise     = rise_w;
    assign act_fall     = fall_w;
endmodule

// File: rtl/pwm_regbank_chk.sv
module pwm_regbank_chk #(
    parameter int unsigned       NUM_CH      = 16,
    parameter logic [NUM_CH-1:0] SHADOW_MASK = {NUM_CH{1'b1}}
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic                period_start,
    input logic [7:0]          act_prescale,
    input logic [7:0]          act_period,
    input logic [NUM_CH-1:0]   act_enable,
    input logic [NUM_CH*8-1:0] act_rise,
    input logic [NUM_CH*8-1:0] act_fall,
    input logic                sync_q
);
    logic unused_chk_wdata;
    assign unused_chk_wdata = ^bus_wdata[31:8];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (act_prescale == '0 && act_period == '0 && act_enable == '0 &&
                 act_rise == '0 && act_fall == '0 && !sync_q));

    // R3
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:8] == '0);

    // R3
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);

    // R6
    prescale_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 8'h00) |=> $stable(act_prescale));

    // R6
    prescale_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h00) |=> act_prescale == $past(bus_wdata[7:0]));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_edge_chk
            localparam logic [7:0] RA = 8'(16 + 8 * c);
            localparam logic [7:0] FA = 8'(20 + 8 * c);
            if (SHADOW_MASK[c]) begin : g_sh
                // R8
                staged_hold_chk: assert property (@(posedge clk) disable iff (rst)
                    (sync_q && !period_start) |=>
                        ($stable(act_rise[c*8 +: 8]) && $stable(act_fall[c*8 +: 8])));
                // R10
                nosync_strobe_chk: assert property (@(posedge clk) disable iff (rst)
                    (!sync_q && !(bus_wr && (bus_addr == RA || bus_addr == FA))) |=>
                        ($stable(act_rise[c*8 +: 8]) && $stable(act_fall[c*8 +: 8])));
                // R7
                direct_write_chk: assert property (@(posedge clk) disable iff (rst)
                    (!sync_q && bus_wr && bus_addr == RA) |=>
                        act_rise[c*8 +: 8] == $past(bus_wdata[7:0]));
            end else begin : g_pl
                // R5
                plain_hold_chk: assert property (@(posedge clk) disable iff (rst)
                    !(bus_wr && (bus_addr == RA || bus_addr == FA)) |=>
                        ($stable(act_rise[c*8 +: 8]) && $stable(act_fall[c*8 +: 8])));
                // R5
                plain_load_chk: assert property (@(posedge clk) disable iff (rst)
                    (bus_wr && bus_addr == FA) |=>
                        act_fall[c*8 +: 8] == $past(bus_wdata[7:0]));
            end
        end
    endgenerate
endmodule

bind pwm_regbank pwm_regbank_chk #(
    .NUM_CH      (NUM_CH),
    .SHADOW_MASK (SHADOW_MASK)
) u_regbank_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .period_start (period_start),
    .act_prescale (act_prescale),
    .act_period   (act_period),
    .act_enable   (act_enable),
    .act_rise     (act_rise),
    .act_fall     (act_fall),
    .sync_q       (sync_q)
);

// File: tb/tb_pwm_regbank.sv
`timescale 1ns/1ps
module tb_pwm_regbank;
    localparam int unsigned       NCH  = 10;
    localparam logic [NCH-1:0]    MASK = 10'b10_0101_0011;

    logic              clk = 1'b0;
    logic              rst;
    logic [7:0]        bus_addr;
    logic              bus_wr;
    logic              bus_rd;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic              period_start;
    logic [7:0]        act_prescale;
    logic [7:0]        act_period;
    logic [NCH-1:0]    act_enable;
    logic [NCH*8-1:0]  act_rise;
    logic [NCH*8-1:0]  act_fall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  m_pre, m_per;
    logic [15:0] m_en;
    logic [7:0]  m_rise [16];
    logic [7:0]  m_fall [16];
    logic [7:0]  s_rise [16];
    logic [7:0]  s_fall [16];
    bit          m_sync;

    always #2.5 clk = ~clk;

    pwm_regbank #(.NUM_CH(NCH), .SHADOW_MASK(MASK)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .period_start(period_start),
        .act_prescale(act_prescale), .act_period(act_period), .act_enable(act_enable),
        .act_rise(act_rise), .act_fall(act_fall)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pre = 0; m_per = 0; m_en = 0; m_sync = 0;
        for (int i = 0; i < 16; i++) begin
            m_rise[i] = 0; m_fall[i] = 0; s_rise[i] = 0; s_fall[i] = 0;
        end
    endtask

    // edge channel of address, or -1 when not an existing edge register
    function automatic int edge_ch(input int a);
        if (a % 4 != 0 || a < 16 || a > 140) return -1;
        if ((a - 16) / 8 >= int'(NCH)) return -1;
        return (a - 16) / 8;
    endfunction

    function automatic bit mapped(input int a);
        return a == 0 || a == 4 || a == 8 || (a == 12 && NCH > 8) || a == 228 || edge_ch(a) >= 0;
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        int ch;
        logic [7:0] v;
        v = 0;
        ch = edge_ch(a);
        if (a == 0) v = m_pre;
        else if (a == 4) v = m_per;
        else if (a == 8) v = m_en[7:0];
        else if (a == 12 && NCH > 8) v = m_en[15:8];
        else if (a == 228) v = {7'd0, m_sync};
        else if (ch >= 0) v = ((a - 16) % 8 == 4) ? m_fall[ch] : m_rise[ch];
        return v;
    endfunction

    task automatic model_write(input int a, input logic [31:0] d, input bit wr, input bit strobe);
        int ch;
        if (strobe && m_sync)
            for (int i = 0; i < int'(NCH); i++)
                if (MASK[i]) begin m_rise[i] = s_rise[i]; m_fall[i] = s_fall[i]; end
        if (!wr) return;
        ch = edge_ch(a);
        if (a == 0) m_pre = d[7:0];
        else if (a == 4) m_per = d[7:0];
        else if (a == 8) begin
            for (int i = 0; i < 8; i++) if (i < int'(NCH)) m_en[i] = d[i];
        end else if (a == 12 && NCH > 8) begin
            for (int i = 8; i < 16; i++) if (i < int'(NCH)) m_en[i] = d[i-8];
        end else if (a == 228) m_sync = d[0];
        else if (ch >= 0) begin
            if ((a - 16) % 8 == 4) begin
                if (MASK[ch]) begin s_fall[ch] = d[7:0]; if (!m_sync) m_fall[ch] = d[7:0]; end
                else m_fall[ch] = d[7:0];
            end else begin
                if (MASK[ch]) begin s_rise[ch] = d[7:0]; if (!m_sync) m_rise[ch] = d[7:0]; end
                else m_rise[ch] = d[7:0];
            end
        end
    endtask

    task automatic cycle(input int a, input logic [31:0] d, input bit wr, input bit strobe);
        @(negedge clk);
        bus_addr = 8'(a); bus_wdata = d; bus_wr = wr; period_start = strobe;
        @(negedge clk);
        bus_wr = 0; period_start = 0;
        model_write(a, d, wr, strobe);
    endtask

    task automatic read_check(input int a, input string tag);
        @(negedge clk);
        bus_addr = 8'(a); bus_rd = 1;
        #1;
        check(mapped(a) ? tag : "R4", bus_rdata, {24'd0, exp_read(a)});
        bus_rd = 0;
    endtask

    task automatic sweep_reads(input string tag);
        for (int a = 0; a < 256; a++) read_check(a, tag);
    endtask

    task automatic check_outputs(input string tag);
        @(negedge clk);
        check({tag, " prescale"}, {24'd0, act_prescale}, {24'd0, m_pre});
        check({tag, " period"}, {24'd0, act_period}, {24'd0, m_per});
        check({tag, " enable"}, 32'(act_enable), 32'(m_en[NCH-1:0]));
        for (int i = 0; i < int'(NCH); i++) begin
            check({tag, " rise"}, {24'd0, act_rise[i*8 +: 8]}, {24'd0, m_rise[i]});
            check({tag, " fall"}, {24'd0, act_fall[i*8 +: 8]}, {24'd0, m_fall[i]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0; period_start = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state on every address and output
        sweep_reads("R1");
        check_outputs("R1");

        // R3: read data idle when read enable low
        cycle(8'h00, 32'hFFFF_FF5A, 1, 0);
        @(negedge clk); bus_addr = 8'h00; bus_rd = 0; #1;
        check("R3 idle", bus_rdata, 32'd0);

        // R2 R4 R5 R6 R7: full write sweep with sync clear, upper data bits set
        for (int a = 0; a < 256; a++)
            if (a != 228) cycle(a, 32'hC3A5_0000 | 32'((a * 37 + 11) & 8'hFF), 1, 0);
        sweep_reads("R2");
        check_outputs("R6");

        // R10: strobe with sync clear changes nothing
        cycle(0, 0, 0, 1);
        check_outputs("R10");

        // R8: sync on, sweep of new values with no strobes
        cycle(228, 32'h1, 1, 0);
        for (int a = 16; a < 144; a += 4) cycle(a, 32'((a * 13 + 5) & 8'hFF), 1, 0);
        sweep_reads("R8");
        check_outputs("R8");
        cycle(0, 0, 0, 1);
        sweep_reads("R8");
        check_outputs("R8");

        // R9: write coinciding with strobe
        cycle(8'h10, 32'h11, 1, 0);
        cycle(8'h10, 32'h22, 1, 1);
        read_check(8'h10, "R9");
        check("R9 first commit", {24'd0, act_rise[7:0]}, 32'h11);
        cycle(0, 0, 0, 1);
        read_check(8'h10, "R9");
        check("R9 second commit", {24'd0, act_rise[7:0]}, 32'h22);

        // R10: pending value survives strobes while sync clear, then commits
        cycle(8'h14, 32'h77, 1, 0);
        cycle(228, 32'h0, 1, 0);
        cycle(0, 0, 0, 1);
        read_check(8'h14, "R10");
        cycle(228, 32'h1, 1, 0);
        cycle(0, 0, 0, 1);
        read_check(8'h14, "R10");
        check("R10 commit", {24'd0, act_fall[7:0]}, 32'h77);

        // R7: immediate write while clear also updates staging
        cycle(228, 32'h0, 1, 0);
        cycle(8'h30, 32'h9C, 1, 0);
        cycle(228, 32'h1, 1, 0);
        cycle(0, 0, 0, 1);
        read_check(8'h30, "R7");

        // strobe-interleaved sweep with sync set (R5 R8 R9)
        for (int a = 0; a < 256; a++)
            if (a != 228) cycle(a, 32'((a * 91 + 3) & 8'hFF), 1, (a % 5) == 0);
        sweep_reads("R5");
        check_outputs("R9");

        // R1: reset mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model_reset();
        sweep_reads("R1");
        check_outputs("R1");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule